// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

The presenter sits between a set of interrupt source controllers and one processor. It keeps one pending interrupt slot, a current processor priority and an inter-processor request level. Source controllers offer interrupts as a source number with an 8-bit priority, and a lower number means more urgent. The presenter either takes the offer or bounces it straight back. A more urgent offer displaces a less urgent pending one, and the displaced interrupt is bounced to its source. The processor sees a single interrupt line, which is high whenever something is pending.

Software works the presenter through single-cycle register strobes. It can poll the state, accept the pending interrupt, set the processor priority, set the inter-processor request level, and signal end-of-interrupt. Toward the sources the block sends bounce pulses, end-of-interrupt pulses and a request that all sources re-offer their interrupts. The inter-processor interrupt is raised by comparing the request level against the processor priority. It has a fixed source number set by a parameter, and it belongs to no source controller.

Top module: `irq_presenter`

## Requirements
- R1: After reset the line is low, no pulse is driven, and a poll returns a status word of 0x00000000 and a request level of 0xFF. The pending priority is internally 0xFF.
- R2: The status word holds the processor priority in bits 31:24 and the pending source number in bits 23:0, where 0 means nothing is pending. Op code 0 (poll) returns the status word and the request level on `rd_xirr`/`rd_mfrr` with `rd_valid` one cycle later, and it changes nothing.
- R3: An offer is bounced on reject lane 1 if its priority is not strictly below the processor priority. It is also bounced if something is already pending at a priority equal to or below its own. An offer with source number 0 is ignored.
- R4: A taken offer bounces any source-owned pending interrupt on lane 1, becomes the pending interrupt and raises the line.
- R5: Op code 1 (accept) returns the pre-operation status word one cycle later and lowers the line. The processor priority becomes the pending priority, the pending source becomes 0 and the pending priority becomes 0xFF.
- R6: Op code 2 writes the request level from `op_data[7:0]`. If that level is below the processor priority and no interrupt is pending at a priority equal to or below it, any source-owned pending interrupt is bounced on lane 0. The inter-processor source number is then loaded with the level as its priority. A pending inter-processor interrupt is never bounced.
- R7: Op code 3 writes the processor priority from `op_data[7:0]`. A new value below the old one, with a pending interrupt whose priority is not below the new value, clears the pending slot and lowers the line. It also bounces an owned interrupt on lane 0. A pending interrupt more urgent than the new value stays.
- R8: A processor priority write that is not below the old value, made while nothing is pending, pulses `resend_req`. If the request level is then below the processor priority, the inter-processor interrupt is presented first.
- R9: Op code 4 (end-of-interrupt) loads the processor priority from `op_data[31:24]` and pulses `eoi_valid` with `op_data[23:0]`. If nothing is pending, it performs the resend of R8.
- R10: When an operation and an offer share a cycle, the operation is applied first and the offer is judged against the result. Bounces caused by the operation use lane 0 and bounces caused by the offer use lane 1.
- R11: Op codes 5 to 7 have no effect.
- R12: The line is high exactly when the pending source number is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Offer strobe from a source controller |
| req_src | input | 24 | Offered source number |
| req_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Register operation strobe |
| op_code | input | 3 | Operation code |
| op_data | input | 32 | Operation write data |
| rd_valid | output | 1 | Read data valid |
| rd_xirr | output | 32 | Status word read back |
| rd_mfrr | output | 8 | Request level read back |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 2 | Bounce pulse per lane |
| rej_src | output | 48 | Bounced source number per lane (lane 0 in bits 23:0) |
| eoi_valid | output | 1 | End-of-interrupt pulse toward sources |
| eoi_src | output | 24 | Source number of the end-of-interrupt |
| resend_req | output | 1 | Request for all sources to re-offer |

## Verification
A register operation and a source offer can arrive in the same cycle, and each can bounce an interrupt. The bench provokes this by pairing a processor priority write that ejects the pending interrupt with an offer that is taken in one case and bounced in another. It also pairs an accept with an offer that the new, more urgent priority must refuse. It judges the outcome from the lane each bounce appears on, the source numbers on both lanes and the final line level. A poll afterwards confirms the resulting status word.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int unsigned PRIO_W    = 8;
    localparam int unsigned SRC_W     = 24;
    localparam int unsigned XIRR_W    = PRIO_W + SRC_W;
    localparam int unsigned NUM_LANES = 2;
    localparam int unsigned LANE_OP   = 0;
    localparam int unsigned LANE_REQ  = 1;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef enum logic [2:0] {
        OP_POLL     = 3'd0,
        OP_ACCEPT   = 3'd1,
        OP_SET_MFRR = 3'd2,
        OP_SET_CPPR = 3'd3,
        OP_EOI      = 3'd4
    } ipr_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;   // processor priority
        logic [SRC_W-1:0]  xisr;   // pending source, 0 = none
        logic [PRIO_W-1:0] pend;   // pending priority
        logic              owned;  // pending belongs to a source controller
        logic [PRIO_W-1:0] mfrr;   // inter-processor request level
        logic              line;   // interrupt line
    } ipr_state_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } ipr_pulse_t;

    localparam ipr_state_t STATE_RESET = '{
        cppr:  '0,
        xisr:  '0,
        pend:  PRIO_NONE,
        owned: 1'b0,
        mfrr:  PRIO_NONE,
        line:  1'b0
    };

    function automatic logic more_urgent(input logic [PRIO_W-1:0] a,
                                         input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction

    function automatic logic [XIRR_W-1:0] status_word(input ipr_state_t s);
        return {s.cppr, s.xisr};
    endfunction

endpackage

// File: rtl/ipr_op_stage.sv
module ipr_op_stage
    import ipr_pkg::*;
#(
    parameter int unsigned IPI_SRC = 2
) (
    input  ipr_state_t         cur,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [XIRR_W-1:0]  op_data,
    output ipr_state_t         nxt,
    output ipr_pulse_t         bounce,
    output ipr_pulse_t         eoi,
    output logic               resend,
    output logic               rd_take
);

    localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

    logic              do_resend;
    logic              do_ipi;
    logic [PRIO_W-1:0] wr_prio;

    assign wr_prio = op_data[PRIO_W-1:0];

    always_comb begin
        nxt       = cur;
        bounce    = '0;
        eoi       = '0;
        resend    = 1'b0;
        rd_take   = 1'b0;
        do_resend = 1'b0;
        do_ipi    = 1'b0;

        if (op_valid) begin
            case (op_code)
                OP_POLL: begin
                    rd_take = 1'b1;
                end
                OP_ACCEPT: begin
                    rd_take   = 1'b1;
                    nxt.cppr  = cur.pend;
                    nxt.xisr  = '0;
                    nxt.pend  = PRIO_NONE;
                    nxt.owned = 1'b0;
                    nxt.line  = 1'b0;
                end
                OP_SET_MFRR: begin
                    nxt.mfrr = wr_prio;
                    do_ipi   = more_urgent(wr_prio, cur.cppr);
                end
                OP_SET_CPPR: begin
                    nxt.cppr = wr_prio;
                    if (more_urgent(wr_prio, cur.cppr)) begin
                        if ((cur.xisr != '0) && (wr_prio <= cur.pend)) begin
                            nxt.xisr  = '0;
                            nxt.pend  = PRIO_NONE;
                            nxt.owned = 1'b0;
                            nxt.line  = 1'b0;
                            if (cur.owned) begin
                                bounce.valid = 1'b1;
                                bounce.src   = cur.xisr;
                            end
                        end
                    end else if (cur.xisr == '0) begin
                        do_resend = 1'b1;
                    end
                end
                OP_EOI: begin
                    nxt.cppr  = op_data[XIRR_W-1:SRC_W];
                    eoi.valid = 1'b1;
                    eoi.src   = op_data[SRC_W-1:0];
                    if (cur.xisr == '0) begin
                        do_resend = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end

        if (do_resend) begin
            resend = 1'b1;
            do_ipi = more_urgent(nxt.mfrr, nxt.cppr);
        end

        if (do_ipi && !((nxt.xisr != '0) && (nxt.pend <= nxt.mfrr))) begin
            if ((nxt.xisr != '0) && nxt.owned) begin
                bounce.valid = 1'b1;
                bounce.src   = nxt.xisr;
            end
            nxt.xisr  = IPI_NUM;
            nxt.pend  = nxt.mfrr;
            nxt.owned = 1'b0;
            nxt.line  = 1'b1;
        end
    end

endmodule

// File: rtl/ipr_req_stage.sv
module ipr_req_stage
    import ipr_pkg::*;
(
    input  ipr_state_t         cur,
    input  logic               req_valid,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [PRIO_W-1:0]  req_prio,
    output ipr_state_t         nxt,
    output ipr_pulse_t         bounce
);

    logic refuse;

    assign refuse = !more_urgent(req_prio, cur.cppr)
                 || ((cur.xisr != '0) && (cur.pend <= req_prio));

    always_comb begin
        nxt    = cur;
        bounce = '0;
        if (req_valid && (req_src != '0)) begin
            if (refuse) begin
                bounce.valid = 1'b1;
                bounce.src   = req_src;
            end else begin
                if ((cur.xisr != '0) && cur.owned) begin
                    bounce.valid = 1'b1;
                    bounce.src   = cur.xisr;
                end
                nxt.xisr  = req_src;
                nxt.pend  = req_prio;
                nxt.owned = 1'b1;
                nxt.line  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import ipr_pkg::*;
#(
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [SRC_W-1:0]           req_src,
    input  logic [PRIO_W-1:0]          req_prio,
    input  logic                       op_valid,
    input  logic [2:0]                 op_code,
    input  logic [XIRR_W-1:0]          op_data,
    output logic                       rd_valid,
    output logic [XIRR_W-1:0]          rd_xirr,
    output logic [PRIO_W-1:0]          rd_mfrr,
    output logic                       irq_out,
    output logic [NUM_LANES-1:0]       rej_valid,
    output logic [NUM_LANES*SRC_W-1:0] rej_src,
    output logic                       eoi_valid,
    output logic [SRC_W-1:0]           eoi_src,
    output logic                       resend_req
);

    ipr_state_t st_q;
    ipr_state_t st_op;
    ipr_state_t st_req;
    ipr_pulse_t lane_pulse [NUM_LANES];
    ipr_pulse_t eoi_pulse;
    logic       resend_pulse;
    logic       rd_take;

    logic [SRC_W-1:0]  cur_xisr;
    logic [PRIO_W-1:0] cur_cppr;

    assign cur_xisr = st_q.xisr;
    assign cur_cppr = st_q.cppr;

    ipr_op_stage #(
        .IPI_SRC (IPI_SRC)
    ) u_op (
        .cur      (st_q),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_data  (op_data),
        .nxt      (st_op),
        .bounce   (lane_pulse[LANE_OP]),
        .eoi      (eoi_pulse),
        .resend   (resend_pulse),
        .rd_take  (rd_take)
    );

    ipr_req_stage u_req (
        .cur       (st_op),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_prio  (req_prio),
        .nxt       (st_req),
        .bounce    (lane_pulse[LANE_REQ])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= STATE_RESET;
            rd_valid   <= 1'b0;
            rd_xirr    <= '0;
            rd_mfrr    <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
            resend_req <= 1'b0;
        end else begin
            st_q       <= st_req;
            rd_valid   <= rd_take;
            eoi_valid  <= eoi_pulse.valid;
            eoi_src    <= eoi_pulse.src;
            resend_req <= resend_pulse;
            if (rd_take) begin
                rd_xirr <= status_word(st_q);
                rd_mfrr <= st_q.mfrr;
            end
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        ipr_pulse_t lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_pulse[l];
            end
        end
        assign rej_valid[l]                 = lane_q.valid;
        assign rej_src[l*SRC_W +: SRC_W]    = lane_q.src;
    end

    assign irq_out = st_q.line;

endmodule

// File: rtl/ipr_checker.sv
module ipr_checker
    import ipr_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [SRC_W-1:0]           req_src,
    input logic [PRIO_W-1:0]          req_prio,
    input logic                       op_valid,
    input logic [2:0]                 op_code,
    input logic [XIRR_W-1:0]          op_data,
    input logic                       rd_valid,
    input logic                       irq_out,
    input logic [NUM_LANES-1:0]       rej_valid,
    input logic [NUM_LANES*SRC_W-1:0] rej_src,
    input logic                       eoi_valid,
    input logic [SRC_W-1:0]           eoi_src,
    input logic [SRC_W-1:0]           cur_xisr,
    input logic [PRIO_W-1:0]          cur_cppr
);

    logic is_read;
    assign is_read = op_valid && ((op_code == OP_POLL) || (op_code == OP_ACCEPT));

    // R12
    a_r12_line_iff_pending: assert property (@(posedge clk) disable iff (rst)
        irq_out == (cur_xisr != '0));

    // R3
    a_r3_refuse_not_urgent: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && req_valid && (req_src != '0) && (req_prio >= cur_cppr))
        |=> (rej_valid[LANE_REQ] && (rej_src[LANE_REQ*SRC_W +: SRC_W] == $past(req_src))));

    // R5
    a_r5_accept_lowers: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_ACCEPT) && !req_valid) |=> !irq_out);

    // R9
    a_r9_eoi_forward: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_EOI))
        |=> (eoi_valid && (eoi_src == $past(op_data[SRC_W-1:0]))));

    // R2
    a_r2_read_follows: assert property (@(posedge clk) disable iff (rst)
        is_read |=> rd_valid);

    a_r2_no_spurious_read: assert property (@(posedge clk) disable iff (rst)
        !is_read |=> !rd_valid);

    // R11
    a_r11_unused_op: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code > OP_EOI) && !req_valid)
        |=> (!rd_valid && (rej_valid == '0) && !eoi_valid && $stable(irq_out)));

endmodule

bind irq_presenter ipr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_prio  (req_prio),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_data   (op_data),
    .rd_valid  (rd_valid),
    .irq_out   (irq_out),
    .rej_valid (rej_valid),
    .rej_src   (rej_src),
    .eoi_valid (eoi_valid),
    .eoi_src   (eoi_src),
    .cur_xisr  (cur_xisr),
    .cur_cppr  (cur_cppr)
);

// File: tb/test_irq_presenter.sv
module test_irq_presenter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        rd_valid;
    logic [31:0] rd_xirr;
    logic [7:0]  rd_mfrr;
    logic        irq_out;
    logic [1:0]  rej_valid;
    logic [47:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_presenter #(.IPI_SRC(2)) i_irq_presenter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .rd_valid(rd_valid), .rd_xirr(rd_xirr), .rd_mfrr(rd_mfrr),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    typedef struct packed {
        logic        ov;
        logic [2:0]  opc;
        logic [31:0] od;
        logic        rv;
        logic [23:0] rs;
        logic [7:0]  rp;
        logic        irq;
        logic [1:0]  rej;
        logic [23:0] r0;
        logic [23:0] r1;
        logic        rsd;
        logic        eoi;
        logic [23:0] es;
        logic        rdv;
        logic [31:0] rdx;
        logic [7:0]  rdm;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    // op codes: 0 poll, 1 accept, 2 request level, 3 processor priority, 4 end-of-interrupt
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'd0,32'h0,       1'b1,24'h10,8'h05, 1'b0,2'b10,24'h0, 24'h10,1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd3},  // R3
        '{1'b1,3'd3,32'hFF,      1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b1,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd8},  // R8
        '{1'b0,3'd0,32'h0,       1'b1,24'h10,8'h05, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd4},  // R4
        '{1'b0,3'd0,32'h0,       1'b1,24'h11,8'h05, 1'b1,2'b10,24'h0, 24'h11,1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd3},  // R3
        '{1'b0,3'd0,32'h0,       1'b1,24'h12,8'h03, 1'b1,2'b10,24'h0, 24'h10,1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd4},  // R4
        '{1'b1,3'd0,32'h0,       1'b0,24'h0, 8'h00, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b1,32'hFF000012,8'hFF,4'd2},  // R2
        '{1'b1,3'd2,32'h04,      1'b0,24'h0, 8'h00, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd6},  // R6
        '{1'b1,3'd2,32'h01,      1'b0,24'h0, 8'h00, 1'b1,2'b01,24'h12,24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd6},  // R6
        '{1'b1,3'd1,32'h0,       1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b1,32'hFF000002,8'h01,4'd5},  // R5
        '{1'b1,3'd4,32'hFF000002,1'b0,24'h0, 8'h00, 1'b1,2'b00,24'h0, 24'h0, 1'b1,1'b1,24'h2, 1'b0,32'h0,       8'h00,4'd9},  // R9
        '{1'b0,3'd0,32'h0,       1'b1,24'h40,8'h00, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd6},  // R6
        '{1'b1,3'd2,32'hFF,      1'b0,24'h0, 8'h00, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd6},  // R6
        '{1'b1,3'd1,32'h0,       1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b1,32'hFF000040,8'hFF,4'd5},  // R5
        '{1'b1,3'd4,32'hFF000040,1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b1,1'b1,24'h40,1'b0,32'h0,       8'h00,4'd9},  // R9
        '{1'b0,3'd0,32'h0,       1'b1,24'h20,8'h08, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd4},  // R4
        '{1'b1,3'd3,32'h06,      1'b1,24'h21,8'h04, 1'b1,2'b01,24'h20,24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd10}, // R10
        '{1'b1,3'd3,32'h02,      1'b1,24'h22,8'h03, 1'b0,2'b11,24'h21,24'h22,1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd10}, // R10
        '{1'b0,3'd0,32'h0,       1'b1,24'h30,8'h00, 1'b1,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd4},  // R4
        '{1'b1,3'd1,32'h0,       1'b1,24'h31,8'h00, 1'b0,2'b10,24'h0, 24'h31,1'b0,1'b0,24'h0, 1'b1,32'h02000030,8'hFF,4'd10}, // R10
        '{1'b1,3'd7,32'hFFFFFFFF,1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd11}, // R11
        '{1'b1,3'd0,32'h0,       1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b1,32'h00000000,8'hFF,4'd11}, // R11
        '{1'b1,3'd3,32'h05,      1'b0,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b1,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd8},  // R8
        '{1'b0,3'd0,32'h0,       1'b1,24'h50,8'h05, 1'b0,2'b10,24'h0, 24'h50,1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd3},  // R3
        '{1'b0,3'd0,32'h0,       1'b1,24'h0, 8'h00, 1'b0,2'b00,24'h0, 24'h0, 1'b0,1'b0,24'h0, 1'b0,32'h0,       8'h00,4'd3}   // R3
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic ov, input logic [2:0] opc, input logic [31:0] od,
                         input logic rv, input logic [23:0] rs, input logic [7:0] rp);
        op_valid  = ov;
        op_code   = opc;
        op_data   = od;
        req_valid = rv;
        req_src   = rs;
        req_prio  = rp;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk(!irq_out && rej_valid == 2'b00 && !rd_valid && !eoi_valid && !resend_req,
            1, "outputs after reset",
            {irq_out, rej_valid, rd_valid, eoi_valid, resend_req}, 64'h0);
        drive(1'b1, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
        chk(rd_valid && rd_xirr == 32'h0 && rd_mfrr == 8'hFF, 1, "poll after reset R1",
            {rd_valid, rd_xirr, rd_mfrr}, {1'b1, 32'h0, 8'hFF});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ov, VEC[i].opc, VEC[i].od, VEC[i].rv, VEC[i].rs, VEC[i].rp);
            chk(irq_out == VEC[i].irq, VEC[i].req, $sformatf("row %0d line", i),
                64'(irq_out), 64'(VEC[i].irq));
            chk(rej_valid == VEC[i].rej
                && (!VEC[i].rej[0] || rej_src[23:0] == VEC[i].r0)
                && (!VEC[i].rej[1] || rej_src[47:24] == VEC[i].r1),
                VEC[i].req, $sformatf("row %0d bounce", i),
                {rej_valid, rej_src}, {VEC[i].rej, VEC[i].r1, VEC[i].r0});
            chk(resend_req == VEC[i].rsd && eoi_valid == VEC[i].eoi
                && (!VEC[i].eoi || eoi_src == VEC[i].es),
                VEC[i].req, $sformatf("row %0d resend/eoi", i),
                {resend_req, eoi_valid, eoi_src}, {VEC[i].rsd, VEC[i].eoi, VEC[i].es});
            chk(rd_valid == VEC[i].rdv
                && (!VEC[i].rdv || (rd_xirr == VEC[i].rdx && rd_mfrr == VEC[i].rdm)),
                VEC[i].req, $sformatf("row %0d read", i),
                {rd_valid, rd_xirr, rd_mfrr}, {VEC[i].rdv, VEC[i].rdx, VEC[i].rdm});
        end

        // R4: processor priority is 5, offer at priority 1 is taken
        drive(1'b0, 3'd0, 32'h0, 1'b1, 24'h60, 8'h01);
        chk(irq_out && rej_valid == 2'b00, 4, "take offer 0x60", {irq_out, rej_valid}, 3'b100);
        // R7: more urgent priority 3 leaves a priority 1 pending interrupt alone
        drive(1'b1, 3'd3, 32'h03, 1'b0, 24'h0, 8'h0);
        chk(irq_out && rej_valid == 2'b00, 7, "no eject when pending is more urgent",
            {irq_out, rej_valid}, 3'b100);
        // R7: priority 1 equals the pending priority, so it is ejected on lane 0
        drive(1'b1, 3'd3, 32'h01, 1'b0, 24'h0, 8'h0);
        chk(!irq_out && rej_valid == 2'b01 && rej_src[23:0] == 24'h60, 7, "eject on equal",
            {irq_out, rej_valid, rej_src[23:0]}, {1'b0, 2'b01, 24'h60});
        drive(1'b1, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
        chk(rd_xirr == 32'h01000000, 12, "slot empty after eject R12", rd_xirr, 32'h01000000);

        // R1: reset mid-run with an interrupt pending
        drive(1'b0, 3'd0, 32'h0, 1'b1, 24'h61, 8'h00);
        chk(irq_out, 4, "take offer 0x61", 64'(irq_out), 64'h1);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        chk(!irq_out, 1, "line low after reset", 64'(irq_out), 64'h0);
        drive(1'b1, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
        chk(rd_xirr == 32'h0 && rd_mfrr == 8'hFF, 1, "poll after second reset",
            {rd_xirr, rd_mfrr}, {32'h0, 8'hFF});
        idle();
        finish_run();
    end

endmodule